// File: doc/BRIEF.md
# Bidirectional Doorbell Interrupt Unit

This block lets a local processor and a PCI-side agent raise interrupts toward each other through doorbell registers. Two register ports, one for the CPU and one for the PCI side, share a single clock and a small register window. The outbound doorbell carries requests toward the PCI side. The CPU sets its bits, the PCI side can also set them through a separate set-only alias, and the PCI side acknowledges them by writing ones. The inbound doorbell carries requests toward the CPU. The PCI side sets its bits and the CPU clears them by writing ones.

Each direction has a mask register. A mask bit at 1 only keeps the matching doorbell bit from driving the interrupt. The doorbell bit still latches when it is written. Each direction has one registered, level-sensitive interrupt output. It is high while at least one doorbell bit is set and unmasked.

Top module: `db_msg_unit`

## Requirements
- R1: After reset both doorbells read 0, both masks read all ones, both interrupt outputs are 0 and both read-data outputs are 0.
- R2: A CPU-port write to offset 0x1C2C (outbound doorbell) sets every outbound bit written as 1 and leaves bits written as 0 unchanged.
- R3: A PCI-port write to offset 0x1C34 (outbound set alias) sets outbound bits in the same way. A CPU-port write to 0x1C34 has no effect.
- R4: A PCI-port write to 0x1C2C clears every outbound bit written as 1. When a set from the CPU port and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: A PCI-port write to 0x1C20 (inbound doorbell) sets the inbound bits written as 1. A CPU-port write to 0x1C20 clears the bits written as 1. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: A write to 0x1C30 (outbound mask) or to 0x1C24 (inbound mask) from either port replaces the whole mask. When both ports write the same mask in the same cycle, the receiving side wins: the PCI port for 0x1C30 and the CPU port for 0x1C24.
- R7: Doorbell bits latch on a setting write whatever the mask holds.
- R8: After each clock edge, pci_irq equals the OR of all bits of (outbound doorbell AND NOT outbound mask) and cpu_irq equals the same expression for the inbound pair. Both use the register values updated at that edge.
- R9: A read is registered. The read-data output in the cycle after an address is presented holds that register's value from before any write in that cycle. The set alias and unmapped offsets read as 0. Reads change no state.
- R10: Writes to unmapped offsets change no register and no interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wen | input | 1 | CPU port write strobe |
| cpu_addr | input | ADDR_W | CPU port byte offset |
| cpu_wdata | input | DW | CPU port write data |
| cpu_rdata | output | DW | CPU port registered read data |
| pci_wen | input | 1 | PCI port write strobe |
| pci_addr | input | ADDR_W | PCI port byte offset |
| pci_wdata | input | DW | PCI port write data |
| pci_rdata | output | DW | PCI port registered read data |
| cpu_irq | output | 1 | Level interrupt toward the CPU (inbound) |
| pci_irq | output | 1 | Level interrupt toward the PCI side (outbound) |

## Verification
Walking-one sweeps over all 32 bits set each doorbell bit while the mask is all ones, which shows that latching does not depend on masking. The bench then opens one mask bit at a time, so an interrupt that follows the wrong bit lane or the wrong mask becomes visible. Clearing sweeps with walking ones, and overlapping set and clear patterns in a single cycle, tell set-wins priority apart from clear-wins priority. The sweeps also tell the roles of the two ports apart. Simultaneous mask writes with different data show which port has priority, and writes to unmapped offsets and the alias from the wrong port must leave a full readback unchanged.

// File: rtl/db_pkg.sv
package db_pkg;

  // Register window offsets (byte addresses)
  localparam logic [15:0] OFS_IN_DB    = 16'h1C20;
  localparam logic [15:0] OFS_IN_MASK  = 16'h1C24;
  localparam logic [15:0] OFS_OUT_DB   = 16'h1C2C;
  localparam logic [15:0] OFS_OUT_MASK = 16'h1C30;
  localparam logic [15:0] OFS_OUT_SET  = 16'h1C34;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN_DB,
    SEL_IN_MASK,
    SEL_OUT_DB,
    SEL_OUT_MASK,
    SEL_OUT_SET
  } reg_sel_e;

endpackage

// File: rtl/db_addr_decode.sv
module db_addr_decode
  import db_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_IN_DB    = ADDR_W'(OFS_IN_DB);
  localparam logic [ADDR_W-1:0] A_IN_MASK  = ADDR_W'(OFS_IN_MASK);
  localparam logic [ADDR_W-1:0] A_OUT_DB   = ADDR_W'(OFS_OUT_DB);
  localparam logic [ADDR_W-1:0] A_OUT_MASK = ADDR_W'(OFS_OUT_MASK);
  localparam logic [ADDR_W-1:0] A_OUT_SET  = ADDR_W'(OFS_OUT_SET);

  always_comb begin
    unique case (addr)
      A_IN_DB:    sel = SEL_IN_DB;
      A_IN_MASK:  sel = SEL_IN_MASK;
      A_OUT_DB:   sel = SEL_OUT_DB;
      A_OUT_MASK: sel = SEL_OUT_MASK;
      A_OUT_SET:  sel = SEL_OUT_SET;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/db_doorbell_reg.sv
module db_doorbell_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_a,
  input  logic [DW-1:0] set_b,
  input  logic [DW-1:0] clr,
  output logic [DW-1:0] q,
  output logic [DW-1:0] nxt
);
  // clear first, then set: set wins on a shared bit
  always_comb nxt = (q & ~clr) | set_a | set_b;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/db_mask_reg.sv
module db_mask_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wen_pri,
  input  logic [DW-1:0] d_pri,
  input  logic          wen_sec,
  input  logic [DW-1:0] d_sec,
  output logic [DW-1:0] q,
  output logic [DW-1:0] nxt
);
  always_comb begin
    if (wen_pri)      nxt = d_pri;
    else if (wen_sec) nxt = d_sec;
    else              nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= nxt;
  end
endmodule

// File: rtl/db_irq_out.sv
module db_irq_out #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] db_nxt,
  input  logic [DW-1:0] mask_nxt,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(db_nxt & ~mask_nxt);
  end
endmodule

// File: rtl/db_read_port.sv
module db_read_port
  import db_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] in_db,
  input  logic [DW-1:0] in_mask,
  input  logic [DW-1:0] out_db,
  input  logic [DW-1:0] out_mask,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mux;

  always_comb begin
    unique case (sel)
      SEL_IN_DB:    mux = in_db;
      SEL_IN_MASK:  mux = in_mask;
      SEL_OUT_DB:   mux = out_db;
      SEL_OUT_MASK: mux = out_mask;
      default:      mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mux;
  end
endmodule

// File: rtl/db_msg_unit.sv
module db_msg_unit
  import db_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wen,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  input  logic              pci_wen,
  input  logic [ADDR_W-1:0] pci_addr,
  input  logic [DW-1:0]     pci_wdata,
  output logic [DW-1:0]     pci_rdata,
  output logic              cpu_irq,
  output logic              pci_irq
);
  localparam int NPORT = 2;  // 0 = CPU, 1 = PCI

  reg_sel_e              sel   [NPORT];
  logic                  wen   [NPORT];
  logic [ADDR_W-1:0]     addr  [NPORT];
  logic [DW-1:0]         wdata [NPORT];
  logic [DW-1:0]         rdata [NPORT];

  logic [DW-1:0] out_db_q, out_db_nxt, in_db_q, in_db_nxt;
  logic [DW-1:0] out_mask_q, out_mask_nxt, in_mask_q, in_mask_nxt;

  always_comb begin
    wen[0] = cpu_wen;  addr[0] = cpu_addr;  wdata[0] = cpu_wdata;
    wen[1] = pci_wen;  addr[1] = pci_addr;  wdata[1] = pci_wdata;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    db_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr[p]),
      .sel  (sel[p])
    );
    db_read_port #(.DW(DW)) u_rd (
      .clk      (clk),
      .rst      (rst),
      .sel      (sel[p]),
      .in_db    (in_db_q),
      .in_mask  (in_mask_q),
      .out_db   (out_db_q),
      .out_mask (out_mask_q),
      .rdata    (rdata[p])
    );
  end

  assign cpu_rdata = rdata[0];
  assign pci_rdata = rdata[1];

  // write strobes per register and port
  logic cpu_w_out_db, cpu_w_in_db, cpu_w_out_mask, cpu_w_in_mask;
  logic pci_w_out_db, pci_w_in_db, pci_w_out_mask, pci_w_in_mask, pci_w_out_set;

  always_comb begin
    cpu_w_out_db   = wen[0] && sel[0] == SEL_OUT_DB;
    cpu_w_in_db    = wen[0] && sel[0] == SEL_IN_DB;
    cpu_w_out_mask = wen[0] && sel[0] == SEL_OUT_MASK;
    cpu_w_in_mask  = wen[0] && sel[0] == SEL_IN_MASK;
    pci_w_out_db   = wen[1] && sel[1] == SEL_OUT_DB;
    pci_w_in_db    = wen[1] && sel[1] == SEL_IN_DB;
    pci_w_out_mask = wen[1] && sel[1] == SEL_OUT_MASK;
    pci_w_in_mask  = wen[1] && sel[1] == SEL_IN_MASK;
    pci_w_out_set  = wen[1] && sel[1] == SEL_OUT_SET;
  end

  // outbound: CPU sets, PCI sets through alias, PCI clears
  db_doorbell_reg #(.DW(DW)) u_out_db (
    .clk   (clk),
    .rst   (rst),
    .set_a (cpu_w_out_db  ? cpu_wdata : '0),
    .set_b (pci_w_out_set ? pci_wdata : '0),
    .clr   (pci_w_out_db  ? pci_wdata : '0),
    .q     (out_db_q),
    .nxt   (out_db_nxt)
  );

  // inbound: PCI sets, CPU clears
  db_doorbell_reg #(.DW(DW)) u_in_db (
    .clk   (clk),
    .rst   (rst),
    .set_a (pci_w_in_db ? pci_wdata : '0),
    .set_b ('0),
    .clr   (cpu_w_in_db ? cpu_wdata : '0),
    .q     (in_db_q),
    .nxt   (in_db_nxt)
  );

  // receiving side has priority on its own mask
  db_mask_reg #(.DW(DW)) u_out_mask (
    .clk     (clk),
    .rst     (rst),
    .wen_pri (pci_w_out_mask),
    .d_pri   (pci_wdata),
    .wen_sec (cpu_w_out_mask),
    .d_sec   (cpu_wdata),
    .q       (out_mask_q),
    .nxt     (out_mask_nxt)
  );

  db_mask_reg #(.DW(DW)) u_in_mask (
    .clk     (clk),
    .rst     (rst),
    .wen_pri (cpu_w_in_mask),
    .d_pri   (cpu_wdata),
    .wen_sec (pci_w_in_mask),
    .d_sec   (pci_wdata),
    .q       (in_mask_q),
    .nxt     (in_mask_nxt)
  );

  db_irq_out #(.DW(DW)) u_pci_irq (
    .clk      (clk),
    .rst      (rst),
    .db_nxt   (out_db_nxt),
    .mask_nxt (out_mask_nxt),
    .irq      (pci_irq)
  );

  db_irq_out #(.DW(DW)) u_cpu_irq (
    .clk      (clk),
    .rst      (rst),
    .db_nxt   (in_db_nxt),
    .mask_nxt (in_mask_nxt),
    .irq      (cpu_irq)
  );
endmodule

// File: rtl/db_msg_unit_chk.sv
module db_msg_unit_chk
  import db_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wen,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DW-1:0]     cpu_wdata,
  input logic [DW-1:0]     cpu_rdata,
  input logic              pci_wen,
  input logic [ADDR_W-1:0] pci_addr,
  input logic [DW-1:0]     pci_wdata,
  input logic [DW-1:0]     pci_rdata,
  input logic              cpu_irq,
  input logic              pci_irq,
  input logic [DW-1:0]     out_db_q,
  input logic [DW-1:0]     in_db_q,
  input logic [DW-1:0]     out_mask_q,
  input logic [DW-1:0]     in_mask_q
);
  localparam logic [ADDR_W-1:0] A_IN_DB    = ADDR_W'(OFS_IN_DB);
  localparam logic [ADDR_W-1:0] A_IN_MASK  = ADDR_W'(OFS_IN_MASK);
  localparam logic [ADDR_W-1:0] A_OUT_DB   = ADDR_W'(OFS_OUT_DB);
  localparam logic [ADDR_W-1:0] A_OUT_MASK = ADDR_W'(OFS_OUT_MASK);
  localparam logic [ADDR_W-1:0] A_OUT_SET  = ADDR_W'(OFS_OUT_SET);

  logic cpu_mapped;
  assign cpu_mapped = cpu_addr == A_IN_DB || cpu_addr == A_IN_MASK ||
                      cpu_addr == A_OUT_DB || cpu_addr == A_OUT_MASK;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!cpu_irq && !pci_irq && out_db_q == '0 && in_db_q == '0 &&
             out_mask_q == '1 && in_mask_q == '1));

  assert_cpu_set_latches_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wen && cpu_addr == A_OUT_DB) |=>
      ((out_db_q & $past(cpu_wdata)) == $past(cpu_wdata)));

  assert_alias_set_latches_R3: assert property (@(posedge clk) disable iff (rst)
    (pci_wen && pci_addr == A_OUT_SET) |=>
      ((out_db_q & $past(pci_wdata)) == $past(pci_wdata)));

  assert_pci_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (pci_wen && pci_addr == A_OUT_DB && !(cpu_wen && cpu_addr == A_OUT_DB)) |=>
      ((out_db_q & $past(pci_wdata)) == '0));

  assert_in_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (pci_wen && pci_addr == A_IN_DB) |=>
      ((in_db_q & $past(pci_wdata)) == $past(pci_wdata)));

  assert_in_mask_cpu_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wen && cpu_addr == A_IN_MASK) |=> (in_mask_q == $past(cpu_wdata)));

  assert_out_mask_pci_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (pci_wen && pci_addr == A_OUT_MASK) |=> (out_mask_q == $past(pci_wdata)));

  assert_pci_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    pci_irq == |(out_db_q & ~out_mask_q));

  assert_cpu_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == |(in_db_q & ~in_mask_q));

  assert_pci_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pci_irq) |-> $past((cpu_wen && (cpu_addr == A_OUT_DB || cpu_addr == A_OUT_MASK)) ||
                             (pci_wen && (pci_addr == A_OUT_SET || pci_addr == A_OUT_MASK))));

  assert_cpu_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_irq) |-> $past((pci_wen && (pci_addr == A_IN_DB || pci_addr == A_IN_MASK)) ||
                             (cpu_wen && cpu_addr == A_IN_MASK)));

  assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !cpu_mapped |=> cpu_rdata == '0);

  assert_no_write_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!cpu_wen && !pci_wen) |=>
      ($stable(out_db_q) && $stable(in_db_q) && $stable(out_mask_q) && $stable(in_mask_q)));

  // pci_rdata is checked by the bench; referenced here to keep every input used
  logic unused_ok;
  assign unused_ok = ^pci_rdata;
endmodule

bind db_msg_unit db_msg_unit_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_wen    (cpu_wen),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .pci_wen    (pci_wen),
  .pci_addr   (pci_addr),
  .pci_wdata  (pci_wdata),
  .pci_rdata  (pci_rdata),
  .cpu_irq    (cpu_irq),
  .pci_irq    (pci_irq),
  .out_db_q   (out_db_q),
  .in_db_q    (in_db_q),
  .out_mask_q (out_mask_q),
  .in_mask_q  (in_mask_q)
);

// File: tb/db_msg_unit_tb.sv
`timescale 1ns/1ps
module db_msg_unit_tb;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam logic [AW-1:0] IN_DB = 16'h1C20, IN_MASK = 16'h1C24,
    OUT_DB = 16'h1C2C, OUT_MASK = 16'h1C30, OUT_SET = 16'h1C34, UNMAP = 16'h1C28;

  logic clk = 0, rst;
  logic cpu_wen, pci_wen;
  logic [AW-1:0] cpu_addr, pci_addr;
  logic [DW-1:0] cpu_wdata, pci_wdata, cpu_rdata, pci_rdata;
  logic cpu_irq, pci_irq;

  always #2 clk = ~clk;

  db_msg_unit #(.DW(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_wen(cpu_wen), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pci_wen(pci_wen), .pci_addr(pci_addr), .pci_wdata(pci_wdata), .pci_rdata(pci_rdata),
    .cpu_irq(cpu_irq), .pci_irq(pci_irq)
  );

  int n_total = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] m_out_db, m_in_db, m_out_mask, m_in_mask;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock with optional writes on both ports; model updated from the rules
  task automatic cyc(input logic cw, input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                     input logic pw, input logic [AW-1:0] pa, input logic [DW-1:0] pd,
                     input string tag);
    logic [DW-1:0] set_o, clr_o, set_i, clr_i;
    @(negedge clk);
    cpu_wen = cw; cpu_addr = ca; cpu_wdata = cd;
    pci_wen = pw; pci_addr = pa; pci_wdata = pd;
    @(posedge clk);
    #1;
    set_o = ((cw && ca == OUT_DB) ? cd : '0) | ((pw && pa == OUT_SET) ? pd : '0);
    clr_o = (pw && pa == OUT_DB) ? pd : '0;
    set_i = (pw && pa == IN_DB) ? pd : '0;
    clr_i = (cw && ca == IN_DB) ? cd : '0;
    m_out_db = (m_out_db & ~clr_o) | set_o;
    m_in_db  = (m_in_db & ~clr_i) | set_i;
    if (pw && pa == OUT_MASK) m_out_mask = pd;
    else if (cw && ca == OUT_MASK) m_out_mask = cd;
    if (cw && ca == IN_MASK) m_in_mask = cd;
    else if (pw && pa == IN_MASK) m_in_mask = pd;
    cpu_wen = 0; pci_wen = 0;
    check(pci_irq == |(m_out_db & ~m_out_mask), {tag, " R8 pci_irq"},
          DW'(pci_irq), DW'(|(m_out_db & ~m_out_mask)));
    check(cpu_irq == |(m_in_db & ~m_in_mask), {tag, " R8 cpu_irq"},
          DW'(cpu_irq), DW'(|(m_in_db & ~m_in_mask)));
  endtask

  task automatic rd(input bit pci, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                    input string tag);
    logic [DW-1:0] got;
    @(negedge clk);
    cpu_wen = 0; pci_wen = 0;
    if (pci) pci_addr = a; else cpu_addr = a;
    @(posedge clk);
    #1;
    got = pci ? pci_rdata : cpu_rdata;
    check(got == exp, tag, got, exp);
  endtask

  task automatic rd_all(input string tag);
    for (int p = 0; p < 2; p++) begin
      rd(p[0], OUT_DB,   m_out_db,   {tag, " R9 out_db"});
      rd(p[0], IN_DB,    m_in_db,    {tag, " R9 in_db"});
      rd(p[0], OUT_MASK, m_out_mask, {tag, " R9 out_mask"});
      rd(p[0], IN_MASK,  m_in_mask,  {tag, " R9 in_mask"});
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst = 1; cpu_wen = 0; pci_wen = 0;
    cpu_addr = '0; pci_addr = '0; cpu_wdata = '0; pci_wdata = '0;
    m_out_db = '0; m_in_db = '0; m_out_mask = '1; m_in_mask = '1;
    repeat (4) @(posedge clk);
    #1;
    check(cpu_rdata == '0 && pci_rdata == '0, "R1 rdata after reset", cpu_rdata | pci_rdata, '0);
    check(!cpu_irq && !pci_irq, "R1 irq after reset", DW'({cpu_irq, pci_irq}), '0);
    @(negedge clk); rst = 0;
    rd_all("R1 reset state");

    // R2 / R7: CPU walking set with everything masked
    for (int i = 0; i < DW; i++) begin
      cyc(1, OUT_DB, DW'(1) << i, 0, '0, '0, "R2 R7 cpu set masked");
      rd(0, OUT_DB, m_out_db, "R2 R7 out_db latched under mask");
    end
    // R6 / R8: open one outbound mask bit at a time from the CPU port
    for (int i = 0; i < DW; i++)
      cyc(1, OUT_MASK, ~(DW'(1) << i), 0, '0, '0, "R6 single unmask");
    // R4: PCI walking clear, with only bit 5 unmasked
    cyc(1, OUT_MASK, ~(DW'(1) << 5), 0, '0, '0, "R6 unmask bit5");
    for (int i = 0; i < DW; i++) begin
      cyc(0, '0, '0, 1, OUT_DB, DW'(1) << i, "R4 pci walking clear");
      rd(1, OUT_DB, m_out_db, "R4 out_db after clear");
    end
    // R3: alias set from PCI, walking
    for (int i = 0; i < DW; i += 3) begin
      cyc(0, '0, '0, 1, OUT_SET, DW'(1) << i, "R3 alias set");
      rd(1, OUT_DB, m_out_db, "R3 out_db after alias set");
    end
    // R3: CPU write to alias ignored
    cyc(0, '0, '0, 1, OUT_DB, '1, "R4 clear all");
    cyc(1, OUT_SET, '1, 0, '0, '0, "R3 cpu alias write");
    rd(0, OUT_DB, 32'h0, "R3 cpu alias write ignored");
    // R4: same-cycle set and clear, set wins on the overlap
    cyc(1, OUT_DB, 32'h00FF_00F0, 0, '0, '0, "R4 preset");
    cyc(1, OUT_DB, 32'h0F0F_0F0F, 1, OUT_DB, 32'hFFFF_0000, "R4 set vs clear");
    rd(1, OUT_DB, m_out_db, "R4 set wins");
    check(m_out_db == 32'h0F0F_0FFF, "R4 expected overlap value", m_out_db, 32'h0F0F_0FFF);

    // R5: inbound walking set by PCI, unmask, CPU clear
    for (int i = 0; i < DW; i++) begin
      cyc(0, '0, '0, 1, IN_DB, DW'(1) << i, "R5 R7 pci in set masked");
      rd(0, IN_DB, m_in_db, "R5 in_db latched");
    end
    for (int i = 0; i < DW; i++)
      cyc(0, '0, '0, 1, IN_MASK, ~(DW'(1) << i), "R6 in single unmask");
    for (int i = 0; i < DW; i++)
      cyc(1, IN_DB, DW'(1) << i, 0, '0, '0, "R5 cpu walking clear");
    rd(0, IN_DB, '0, "R5 in_db cleared");
    cyc(1, IN_DB, 32'hFFFF_FFFF, 1, IN_DB, 32'h8000_0001, "R5 set vs clear");
    rd(1, IN_DB, 32'h8000_0001, "R5 set wins");

    // R6: simultaneous mask writes
    cyc(1, OUT_MASK, 32'hAAAA_AAAA, 1, OUT_MASK, 32'h5555_5555, "R6 both out_mask");
    rd(0, OUT_MASK, 32'h5555_5555, "R6 pci wins out_mask");
    cyc(1, IN_MASK, 32'h1234_5678, 1, IN_MASK, 32'h8765_4321, "R6 both in_mask");
    rd(1, IN_MASK, 32'h1234_5678, "R6 cpu wins in_mask");

    // R10: unmapped writes change nothing
    for (int k = 0; k < 8; k++)
      cyc(1, UNMAP + AW'(k * 64), '1, 1, 16'h0000 + AW'(k * 4), '1, "R10 unmapped write");
    rd_all("R10 after unmapped writes");

    // R9: unmapped/alias read zero, repeated reads unchanged
    rd(0, UNMAP, '0, "R9 unmapped read");
    rd(1, OUT_SET, '0, "R9 alias read");
    rd_all("R9 repeat read 1");
    rd_all("R9 repeat read 2");

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule